// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a 9-bit-wide first-in first-out buffer. Its write side and its read side each run on their own clock, and the two clocks may be unrelated or tied together. Storage is an inferred dual-port array whose depth is a power-of-two parameter from 512 to 4096 words. Four active-low flags report the fill state. Empty and almost-empty are registered on the read clock, and full and almost-full on the write clock. Read data leaves through a registered output.

One input does two jobs. The level it holds while reset is active decides its role for the whole session that follows. If it is held high, it is a second write enable. If it is held low, it is a load strobe. The strobe steers write-port cycles into a small bank of offset registers, and those registers set the almost-empty and almost-full thresholds. Each pointer is kept one bit wider than the address. It crosses into the other domain as Gray code through two synchronizing flops, and each flag is computed from the synchronized pointer ahead of its single output flop.

Top module: `dcfifo_pflag`

## Requirements
- R1: On a rising write clock, a word from `din` is stored and the write pointer advances only when `wen1_n` is low, `en2_ld` is high and `full_n` is high.
- R2: On a rising read clock, the next stored word is loaded into `dout` only when `ren1_n` and `ren2_n` are both low and `empty_n` is high. `dout` holds its value while either read enable is high.
- R3: While `rst_n` is low, both pointers return to location zero, `full_n` and `afull_n` are high, `empty_n` and `aempty_n` are low, `dout` is all zeros, and both offsets take their default value.
- R4: If `en2_ld` is high on the write-clock edges during reset, it acts as a second write enable for the session (a low level blocks writes), and the thresholds stay at their defaults.
- R5: If `en2_ld` is low on the write-clock edges during reset, a write-clock edge with `wen1_n` low and `en2_ld` low loads an offset register and stores nothing in the FIFO.
- R6: Offset loads go in a fixed cycle: empty offset low byte (`din[7:0]`), empty offset high bits (`din[AW-9:0]`, AW = log2 depth), full offset low byte, full offset high bits, then back to the first. The position in this cycle is kept while the strobe is released.
- R7: `aempty_n` is low when the word count is at most the empty offset. `afull_n` is low when the free space is at most the full offset. Both offsets default to 7.
- R8: Writes while full and reads while empty have no effect. With no reads, `full_n` falls on exactly the depth-th write.
- R9: The flag on the side that moves the pointer updates on that same edge. With the clocks tied, the opposite flag clears on the third edge after the operation.
- R10: A read and a write on the same edge keep the word order and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, both domains |
| din | input | 9 | Write data / offset load data |
| wen1_n | input | 1 | Write enable, active low |
| en2_ld | input | 1 | Second write enable (high) or offset load strobe (low) |
| ren1_n | input | 1 | Read enable one, active low |
| ren2_n | input | 1 | Read enable two, active low |
| dout | output | 9 | Registered read data |
| empty_n | output | 1 | Low when empty (read clock) |
| full_n | output | 1 | Low when full (write clock) |
| aempty_n | output | 1 | Low when almost empty (read clock) |
| afull_n | output | 1 | Low when almost full (write clock) |

## Verification
A write and a read can land on the same clock edge. Each then moves its own pointer while the other side's flag still lags through the synchronizer. The bench ties both clocks and, with about a hundred words already queued, drives both enables together for fifty edges. Each returned word is compared with the front of an arithmetic queue model, and the flags must show a constant fill level once the pointers settle.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
    localparam int unsigned WORD_W     = 9;
    localparam int unsigned DEF_OFFSET = 7;

    typedef enum logic [1:0] {
        OFS_E_LO = 2'd0,
        OFS_E_HI = 2'd1,
        OFS_F_LO = 2'd2,
        OFS_F_HI = 2'd3
    } ofs_sel_e;
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            q    <= '0;
        end else begin
            s1_q <= d;
            q    <= s1_q;
        end
    end
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
    parameter int unsigned AW = 9,
    parameter int unsigned W  = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int unsigned WORDS = 1 << AW;

    logic [W-1:0] mem [0:WORDS-1];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcfifo_offsets.sv
module dcfifo_offsets
    import dcfifo_pkg::*;
#(
    parameter int unsigned AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [7:0]    din,
    output logic [AW-1:0] eoff,
    output logic [AW-1:0] foff
);
    localparam int unsigned HI_W = AW - 8;

    typedef struct packed {
        ofs_sel_e      sel;
        logic [AW-1:0] eoff;
        logic [AW-1:0] foff;
    } ofs_st_t;

    ofs_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            case (st_q.sel)
                OFS_E_LO: st_d.eoff[7:0]    = din;
                OFS_E_HI: st_d.eoff[AW-1:8] = din[HI_W-1:0];
                OFS_F_LO: st_d.foff[7:0]    = din;
                default:  st_d.foff[AW-1:8] = din[HI_W-1:0];
            endcase
            st_d.sel = ofs_sel_e'(st_q.sel + 2'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sel: OFS_E_LO, eoff: AW'(DEF_OFFSET), foff: AW'(DEF_OFFSET)};
        end else begin
            st_q <= st_d;
        end
    end

    assign eoff = st_q.eoff;
    assign foff = st_q.foff;
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
    import dcfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 512
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] din,
    input  logic              wen1_n,
    input  logic              en2_ld,
    input  logic              ren1_n,
    input  logic              ren2_n,
    output logic [WORD_W-1:0] dout,
    output logic              empty_n,
    output logic              full_n,
    output logic              aempty_n,
    output logic              afull_n
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full_n;
        logic          afull_n;
    } wr_st_t;

    typedef struct packed {
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        logic              empty_n;
        logic              aempty_n;
        logic [WORD_W-1:0] dout;
    } rd_st_t;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    wr_st_t wr_d, wr_q;
    rd_st_t rd_d, rd_q;

    logic [PW-1:0]     rgray_s, wgray_s;
    logic [AW-1:0]     eoff, foff;
    logic [WORD_W-1:0] ram_rdata;
    logic              wr_go, ld_go, rd_go;
    logic              ld_mode_q;
    logic [PW-1:0]     wbin_w, rbin_w;

    // role of en2_ld, captured on write-clock edges while reset is held
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            ld_mode_q <= !en2_ld;
        end
    end

    // write domain next state
    always_comb begin
        logic [PW-1:0] nx, used, free_w;
        wr_go  = !wen1_n && en2_ld && wr_q.full_n;
        ld_go  = ld_mode_q && !wen1_n && !en2_ld;
        nx     = wr_q.bin + PW'(wr_go);
        used   = nx - gray_to_bin(rgray_s);
        free_w = PW'(DEPTH) - used;
        wr_d          = wr_q;
        wr_d.bin      = nx;
        wr_d.gray     = nx ^ (nx >> 1);
        wr_d.full_n   = (used != PW'(DEPTH));
        wr_d.afull_n  = (free_w > PW'(foff));
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '{bin: '0, gray: '0, full_n: 1'b1, afull_n: 1'b1};
        end else begin
            wr_q <= wr_d;
        end
    end

    // read domain next state
    always_comb begin
        logic [PW-1:0] nx, cnt;
        rd_go = !ren1_n && !ren2_n && rd_q.empty_n;
        nx    = rd_q.bin + PW'(rd_go);
        cnt   = gray_to_bin(wgray_s) - nx;
        rd_d          = rd_q;
        rd_d.bin      = nx;
        rd_d.gray     = nx ^ (nx >> 1);
        rd_d.empty_n  = (cnt != '0);
        rd_d.aempty_n = (cnt > PW'(eoff));
        rd_d.dout     = rd_go ? ram_rdata : rd_q.dout;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '{bin: '0, gray: '0, empty_n: 1'b0, aempty_n: 1'b0, dout: '0};
        end else begin
            rd_q <= rd_d;
        end
    end

    dcfifo_sync #(.W(PW)) u_sync_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rd_q.gray),
        .q     (rgray_s)
    );

    dcfifo_sync #(.W(PW)) u_sync_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wr_q.gray),
        .q     (wgray_s)
    );

    dcfifo_ram #(.AW(AW), .W(WORD_W)) u_ram (
        .wclk  (wclk),
        .we    (wr_go),
        .waddr (wr_q.bin[AW-1:0]),
        .wdata (din),
        .raddr (rd_q.bin[AW-1:0]),
        .rdata (ram_rdata)
    );

    dcfifo_offsets #(.AW(AW)) u_offsets (
        .clk   (wclk),
        .rst_n (rst_n),
        .ld    (ld_go),
        .din   (din[7:0]),
        .eoff  (eoff),
        .foff  (foff)
    );

    assign wbin_w   = wr_q.bin;
    assign rbin_w   = rd_q.bin;
    assign dout     = rd_q.dout;
    assign empty_n  = rd_q.empty_n;
    assign aempty_n = rd_q.aempty_n;
    assign full_n   = wr_q.full_n;
    assign afull_n  = wr_q.afull_n;
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
    parameter int unsigned PW = 10
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wen1_n,
    input logic          en2_ld,
    input logic          ren1_n,
    input logic          ren2_n,
    input logic [8:0]    dout,
    input logic          empty_n,
    input logic          full_n,
    input logic          aempty_n,
    input logic          afull_n,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] rbin
);
    assert_reset_state_R3: assert property (@(posedge wclk)
        !rst_n |-> (full_n && afull_n && !empty_n && !aempty_n && dout == '0));

    assert_no_overflow_R8: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && !wen1_n) |=> $stable(wbin));

    assert_no_underflow_R8: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> ($stable(rbin) && $stable(dout)));

    assert_dout_hold_R2: assert property (@(posedge rclk) disable iff (!rst_n)
        (ren1_n || ren2_n) |=> $stable(dout));

    assert_strobe_low_no_store_R5: assert property (@(posedge wclk) disable iff (!rst_n)
        !en2_ld |=> $stable(wbin));

    assert_full_within_afull_R7: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !afull_n);

    assert_empty_within_aempty_R7: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.PW(PW)) u_chk (
    .wclk     (wclk),
    .rclk     (rclk),
    .rst_n    (rst_n),
    .wen1_n   (wen1_n),
    .en2_ld   (en2_ld),
    .ren1_n   (ren1_n),
    .ren2_n   (ren2_n),
    .dout     (dout),
    .empty_n  (empty_n),
    .full_n   (full_n),
    .aempty_n (aempty_n),
    .afull_n  (afull_n),
    .wbin     (wbin_w),
    .rbin     (rbin_w)
);

// File: tb/dcfifo_pflag_bench.sv
module dcfifo_pflag_bench;
    localparam int DEPTH = 512;

    logic       clk = 1'b0;
    logic       rst_n, wen1_n, en2_ld, ren1_n, ren2_n;
    logic [8:0] din, dout;
    logic       empty_n, full_n, aempty_n, afull_n;
    int         checks = 0;
    int         errors = 0;
    int         model[$];

    always #4 clk = ~clk;

    dcfifo_pflag #(.DEPTH(DEPTH)) u_dcfifo_pflag (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .din(din),
        .wen1_n(wen1_n), .en2_ld(en2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n),
        .dout(dout), .empty_n(empty_n), .full_n(full_n),
        .aempty_n(aempty_n), .afull_n(afull_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input bit w, input bit l, input bit r, input int d);
        wen1_n = !(w || l);
        en2_ld = !l;
        ren1_n = !r;
        ren2_n = !r;
        din    = 9'(d);
        @(posedge clk);
        @(negedge clk);
        wen1_n = 1'b1; en2_ld = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) step(0, 0, 0, 0);
    endtask

    task automatic wr(input int d);
        step(1, 0, 0, d);
        if (model.size() < DEPTH) model.push_back(d);
    endtask

    task automatic rd_chk(input string req);
        int e;
        e = model.pop_front();
        step(0, 0, 1, 0);
        chk(dout == 9'(e), req, int'(dout), e);
    endtask

    task automatic do_reset(input bit ldm);
        rst_n = 1'b0;
        en2_ld = !ldm;
        wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        en2_ld = 1'b1;
        model.delete();
    endtask

    task automatic chk_reset_state(input string req);
        chk(empty_n == 1'b0, req, int'(empty_n), 0);
        chk(aempty_n == 1'b0, req, int'(aempty_n), 0);
        chk(full_n == 1'b1, req, int'(full_n), 1);
        chk(afull_n == 1'b1, req, int'(afull_n), 1);
        chk(dout == 9'd0, req, int'(dout), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int last, e, d, rem;
        rst_n = 1'b1; din = '0; wen1_n = 1'b1; en2_ld = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        #2;
        do_reset(1'b0);
        chk_reset_state("R3 reset");

        // R9: empty clears on the third edge after a write; R1 store
        wr('h155);
        idle(1); chk(empty_n == 1'b0, "R9 empty lag1", int'(empty_n), 0);
        idle(1); chk(empty_n == 1'b0, "R9 empty lag2", int'(empty_n), 0);
        idle(1); chk(empty_n == 1'b1, "R9 empty lag3", int'(empty_n), 1);
        chk(aempty_n == 1'b0, "R7 aempty one word", int'(aempty_n), 0);
        rd_chk("R2 first read");
        chk(empty_n == 1'b0, "R9 empty same edge", int'(empty_n), 0);
        last = int'(dout);
        step(0, 0, 1, 0);
        chk(dout == 9'(last), "R8 read while empty", int'(dout), last);

        // R4: second enable low blocks the write in dual-enable session
        step(0, 1, 0, 'h0AA);
        idle(4);
        chk(empty_n == 1'b0, "R4 enable low no write", int'(empty_n), 0);

        // R1/R7/R8: fill sweep with default offset
        for (int i = 0; i < DEPTH; i++) begin
            wr((i * 37 + 1) & 'h1FF);
            chk(full_n == ((i + 1) < DEPTH), "R8 full count", int'(full_n), int'((i + 1) < DEPTH));
            chk(afull_n == ((DEPTH - (i + 1)) > 7), "R7 afull default", int'(afull_n), int'((DEPTH - (i + 1)) > 7));
        end
        step(1, 0, 0, 'h1FF);
        chk(full_n == 1'b0, "R8 write while full", int'(full_n), 0);
        idle(4);

        // R2/R7/R9: drain sweep
        for (int i = 0; i < DEPTH; i++) begin
            if (i == 100) begin
                last = int'(dout);
                ren1_n = 1'b0; ren2_n = 1'b1;
                @(posedge clk); @(negedge clk);
                ren1_n = 1'b1;
                chk(dout == 9'(last), "R2 hold one enable", int'(dout), last);
            end
            rd_chk("R2 drain order");
            rem = model.size();
            chk(empty_n == (rem > 0), "R9 empty flag", int'(empty_n), int'(rem > 0));
            chk(aempty_n == (rem > 7), "R7 aempty default", int'(aempty_n), int'(rem > 7));
            if (i == 2) chk(full_n == 1'b0, "R9 full lag2", int'(full_n), 0);
            if (i == 3) chk(full_n == 1'b1, "R9 full lag3", int'(full_n), 1);
        end
        last = int'(dout);
        step(0, 0, 1, 0);
        chk(dout == 9'(last), "R8 underflow ignored", int'(dout), last);

        // R10: simultaneous read and write
        for (int i = 0; i < 100; i++) wr('h100 | ((i * 11 + 3) & 'hFF));
        idle(4);
        for (int i = 0; i < 50; i++) begin
            e = model.pop_front();
            d = 'h100 | ((i * 5 + 200) & 'hFF);
            model.push_back(d);
            step(1, 0, 1, d);
            chk(dout == 9'(e), "R10 concurrent order", int'(dout), e);
        end
        idle(4);
        chk(empty_n == 1'b1 && full_n == 1'b1, "R10 count kept", int'(empty_n & full_n), 1);
        for (int i = 0; i < 60; i++) rd_chk("R10 order after concurrent");
        chk(model.size() == 40 && aempty_n == 1'b1, "R10 remaining", int'(aempty_n), 1);

        // R3: reset clears dout; start load-strobe session
        do_reset(1'b1);
        chk_reset_state("R3 reset after data");

        // R5/R6: offset loads with a release between, then wrap
        step(0, 1, 0, 3);
        idle(1);
        step(0, 1, 0, 0);
        step(0, 1, 0, 4);
        step(0, 1, 0, 1);
        step(0, 1, 0, 5);
        idle(4);
        chk(empty_n == 1'b0, "R5 loads not stored", int'(empty_n), 0);
        for (int i = 0; i < 5; i++) wr(i + 40);
        idle(4);
        chk(aempty_n == 1'b0, "R6 eoff wrap at 5", int'(aempty_n), 0);
        wr(45);
        idle(4);
        chk(aempty_n == 1'b1, "R6 eoff wrap above 5", int'(aempty_n), 1);
        for (int c = 7; c <= 260; c++) begin
            wr(c);
            chk(afull_n == ((DEPTH - c) > 260), "R6 foff high bits", int'(afull_n), int'((DEPTH - c) > 260));
        end
        idle(4);
        rd_chk("R5 first word is data");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule